// File: doc/BRIEF.md
# Carrier Interrupt Aggregator

This block gathers the interrupt requests of a carrier that hosts several plug-in modules and presents them to the host as one level-sensitive interrupt line. Every module drives two active-low request lines. Each line passes through a synchronizer and becomes its own pending bit, but only while that module's enable is set. A further source, an access time-out event raised by the carrier's own bus logic, sets a sticky pending bit when its enable is set. Software clears that bit by writing a one.

The host line rises when any pending bit exists and the carrier-wide pass-through enable is set. A summary output reports whether anything is pending, whatever the pass-through enable says. A module's pending bits follow its request level. Service software acknowledges a module by accessing that module's interrupt-select space, the module releases its line, and the pending bit and then the host line fall without any further write.

Top module: `carrier_irq_agg`

## Requirements
- R1: A synchronous active-high reset clears every pending bit, the summary output and the host line on the next clock edge. This holds even while requests are being driven.
- R2: Each of the NUM_MODS modules has REQ_PER_MOD request lines. Request line k of module m is bit m*REQ_PER_MOD+k of `mod_req_n` and appears on the same bit of `pend_mod`. A low input is a request.
- R3: A request reaches its pending bit on the third rising edge after it changes: two synchronizer stages and then the pending register. The bit clears the same way when the line returns high.
- R4: While bit m of `mod_ien` is 0, both pending bits of module m read 0. A change of the enable takes effect on the next clock edge.
- R5: `pend_tmo` is set on the edge where `tmo_event` is high, but only if `tmo_ien` is also high. An event with `tmo_ien` low leaves it at 0.
- R6: `pend_tmo` stays set until `tmo_clr` is 1 on an edge. If `tmo_event` with `tmo_ien` arrives on the same edge as `tmo_clr`, the bit stays set.
- R7: `host_irq` equals, one clock later, `carrier_ien` ANDed with the OR of all `pend_mod` bits and `pend_tmo`.
- R8: `pend_any` equals, one clock later, the OR of all `pend_mod` bits and `pend_tmo`, independent of `carrier_ien`.
- R9: After the last pending bit clears, `host_irq` falls on the following clock edge.
- R10: Clearing `tmo_ien` while `pend_tmo` is set leaves `pend_tmo` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_req_n | input | NUM_MODS*REQ_PER_MOD | Module request lines, active low, asynchronous |
| mod_ien | input | NUM_MODS | Per-module interrupt enable |
| carrier_ien | input | 1 | Carrier-wide pass-through enable for the host line |
| tmo_ien | input | 1 | Access time-out interrupt enable |
| tmo_event | input | 1 | One-cycle access time-out event |
| tmo_clr | input | 1 | Write-one-to-clear strobe for the time-out pending bit |
| pend_mod | output | NUM_MODS*REQ_PER_MOD | Per-line module pending bits |
| pend_tmo | output | 1 | Time-out pending bit |
| pend_any | output | 1 | Summary: at least one pending bit is set |
| host_irq | output | 1 | Level-sensitive host interrupt request |

## Verification
The hardest case to reach is a time-out event and its clear strobe landing on the same clock edge. Both are single-cycle strobes, and the event only matters while its enable is set. The stimulus therefore first sets the sticky bit, then raises event and clear together on one negative edge and checks that the bit survives. After that it lets the clear act alone. A second awkward case is a module enable rising while that module's requests are already synchronized. The bench holds requests low with the enable off until the pipeline has settled, then turns the enable on and checks that the pending bits appear after one edge rather than three.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DEF_MODS  = 5;
  localparam int DEF_REQS  = 2;
  localparam int DEF_SYNC  = 2;

  typedef struct packed {
    logic ien;
    logic evt;
    logic clr;
  } tmo_ctrl_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int   WIDTH   = 10,
  parameter int   STAGES  = 2,
  parameter logic IDLE    = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= {WIDTH{IDLE}};
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/irq_mod_pend.sv
module irq_mod_pend #(
  parameter int NUM_MODS    = 5,
  parameter int REQ_PER_MOD = 2,
  localparam int NREQ       = NUM_MODS * REQ_PER_MOD
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NREQ-1:0]     req,
  input  logic [NUM_MODS-1:0] mod_ien,
  output logic [NREQ-1:0]     pend
);
  for (genvar m = 0; m < NUM_MODS; m++) begin : g_mod
    always_ff @(posedge clk) begin
      if (rst) pend[m*REQ_PER_MOD +: REQ_PER_MOD] <= '0;
      else     pend[m*REQ_PER_MOD +: REQ_PER_MOD] <=
                 req[m*REQ_PER_MOD +: REQ_PER_MOD] & {REQ_PER_MOD{mod_ien[m]}};
    end
  end
endmodule

// File: rtl/irq_tmo_pend.sv
module irq_tmo_pend
  import irq_agg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  tmo_ctrl_t ctl,
  output logic      pend
);
  logic set_now;
  assign set_now = ctl.evt & ctl.ien;

  always_ff @(posedge clk) begin
    if (rst)          pend <= 1'b0;
    else if (set_now) pend <= 1'b1;
    else if (ctl.clr) pend <= 1'b0;
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int NREQ = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] pend_mod,
  input  logic            pend_tmo,
  input  logic            carrier_ien,
  output logic            pend_any,
  output logic            host_irq
);
  logic any_src;
  assign any_src = (|pend_mod) | pend_tmo;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_any <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      pend_any <= any_src;
      host_irq <= any_src & carrier_ien;
    end
  end
endmodule

// File: rtl/carrier_irq_agg.sv
module carrier_irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_MODS    = DEF_MODS,
  parameter int REQ_PER_MOD = DEF_REQS,
  parameter int SYNC_STAGES = DEF_SYNC,
  localparam int NREQ       = NUM_MODS * REQ_PER_MOD
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NREQ-1:0]     mod_req_n,
  input  logic [NUM_MODS-1:0] mod_ien,
  input  logic                carrier_ien,
  input  logic                tmo_ien,
  input  logic                tmo_event,
  input  logic                tmo_clr,
  output logic [NREQ-1:0]     pend_mod,
  output logic                pend_tmo,
  output logic                pend_any,
  output logic                host_irq
);
  logic [NREQ-1:0] req_n_sync;
  logic [NREQ-1:0] req_act;
  tmo_ctrl_t       tctl;

  irq_sync #(.WIDTH(NREQ), .STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
    .clk(clk), .rst(rst), .din(mod_req_n), .dout(req_n_sync)
  );

  assign req_act = ~req_n_sync;

  irq_mod_pend #(.NUM_MODS(NUM_MODS), .REQ_PER_MOD(REQ_PER_MOD)) u_mpend (
    .clk(clk), .rst(rst), .req(req_act), .mod_ien(mod_ien), .pend(pend_mod)
  );

  assign tctl = '{ien: tmo_ien, evt: tmo_event, clr: tmo_clr};

  irq_tmo_pend u_tpend (
    .clk(clk), .rst(rst), .ctl(tctl), .pend(pend_tmo)
  );

  irq_out_stage #(.NREQ(NREQ)) u_out (
    .clk(clk), .rst(rst), .pend_mod(pend_mod), .pend_tmo(pend_tmo),
    .carrier_ien(carrier_ien), .pend_any(pend_any), .host_irq(host_irq)
  );
endmodule

// File: rtl/carrier_irq_agg_chk.sv
module carrier_irq_agg_chk #(
  parameter int NUM_MODS    = 5,
  parameter int REQ_PER_MOD = 2,
  localparam int NREQ       = NUM_MODS * REQ_PER_MOD
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_MODS-1:0] mod_ien,
  input logic                carrier_ien,
  input logic                tmo_ien,
  input logic                tmo_event,
  input logic                tmo_clr,
  input logic [NREQ-1:0]     pend_mod,
  input logic                pend_tmo,
  input logic                pend_any,
  input logic                host_irq
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (pend_mod == '0 && !pend_tmo && !pend_any && !host_irq));

  for (genvar m = 0; m < NUM_MODS; m++) begin : g_chk
    assert_mod_gate_R4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(mod_ien[m])) |-> (pend_mod[m*REQ_PER_MOD +: REQ_PER_MOD] == '0));
  end

  assert_tmo_enable_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(pend_tmo)) |-> $past(tmo_event && tmo_ien));

  assert_tmo_set_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tmo_event && tmo_ien)) |-> pend_tmo);

  assert_tmo_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pend_tmo) && !$past(tmo_clr)) |-> pend_tmo);

  assert_host_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (host_irq == $past(carrier_ien && ((|pend_mod) || pend_tmo))));

  assert_summary_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pend_any == $past((|pend_mod) || pend_tmo)));
endmodule

bind carrier_irq_agg carrier_irq_agg_chk #(
  .NUM_MODS(NUM_MODS), .REQ_PER_MOD(REQ_PER_MOD)
) u_chk (
  .clk(clk), .rst(rst), .mod_ien(mod_ien), .carrier_ien(carrier_ien),
  .tmo_ien(tmo_ien), .tmo_event(tmo_event), .tmo_clr(tmo_clr),
  .pend_mod(pend_mod), .pend_tmo(pend_tmo), .pend_any(pend_any),
  .host_irq(host_irq)
);

// File: tb/test_carrier_irq_agg.sv
`timescale 1ns/1ps
module test_carrier_irq_agg;
  localparam int NM = 5;
  localparam int NR = 2;
  localparam int NQ = NM * NR;

  logic          clk = 1'b0;
  logic          rst;
  logic [NQ-1:0] req_n;
  logic [NM-1:0] ien;
  logic          cien, tien, tev, tclr;
  logic [NQ-1:0] pend_mod;
  logic          pend_tmo, pend_any, host_irq;

  always #2.5 clk = ~clk;

  carrier_irq_agg #(.NUM_MODS(NM), .REQ_PER_MOD(NR), .SYNC_STAGES(2)) i_carrier_irq_agg (
    .clk(clk), .rst(rst), .mod_req_n(req_n), .mod_ien(ien), .carrier_ien(cien),
    .tmo_ien(tien), .tmo_event(tev), .tmo_clr(tclr),
    .pend_mod(pend_mod), .pend_tmo(pend_tmo), .pend_any(pend_any), .host_irq(host_irq)
  );

  typedef struct {
    int            cyc;
    logic [NQ-1:0] pm;
    logic          pt;
    logic          pa;
    logic          hi;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  task automatic push(int n, logic [NQ-1:0] pm, logic pt, logic pa, logic hi, string tag);
    exp_t e;
    e.cyc = cyc + n; e.pm = pm; e.pt = pt; e.pa = pa; e.hi = hi; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_neg(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected items when their cycle arrives
  always @(posedge clk) begin
    #1;
    cyc++;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (pend_mod !== e.pm || pend_tmo !== e.pt || pend_any !== e.pa || host_irq !== e.hi) begin
        n_bad++;
        $display("FAIL %s: actual pm=%h pt=%b pa=%b hi=%b expected pm=%h pt=%b pa=%b hi=%b",
                 e.tag, pend_mod, pend_tmo, pend_any, host_irq, e.pm, e.pt, e.pa, e.hi);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_n = '1; ien = '1; cien = 1'b1; tien = 1'b0; tev = 1'b0; tclr = 1'b0;
    wait_neg(4);
    rst = 1'b0;
    push(1, '0, 0, 0, 0, "R1 reset state");
    wait_neg(3);

    // R3 latency, R2 bit position, R7 and R8 one cycle later
    req_n[3] = 1'b0;
    push(2, '0, 0, 0, 0, "R3 not yet through sync");
    push(3, 10'h008, 0, 0, 0, "R3 pending on third edge");
    push(4, 10'h008, 0, 1, 1, "R7 R8 host and summary");
    wait_neg(6);
    req_n = '1;
    push(3, '0, 0, 1, 1, "R3 release clears pending");
    push(4, '0, 0, 0, 0, "R9 host falls next edge");
    wait_neg(6);

    // R2 other patterns
    req_n[0] = 1'b0; req_n[9] = 1'b0;
    push(4, 10'h201, 0, 1, 1, "R2 module0 line0 and module4 line1");
    wait_neg(5);
    req_n = '1; req_n[4] = 1'b0; req_n[5] = 1'b0;
    push(4, 10'h030, 0, 1, 1, "R2 both lines of module2");
    wait_neg(5);
    req_n = '1;
    wait_neg(6);

    // R4 per-module gating
    ien = 5'b11101; req_n = '0;
    push(4, 10'h3F3, 0, 1, 1, "R4 module1 disabled");
    wait_neg(5);
    ien = '1;
    push(1, 10'h3FF, 0, 1, 1, "R4 enable acts next edge");
    wait_neg(3);
    req_n = '1;
    wait_neg(6);
    ien = '0; req_n[0] = 1'b0;
    push(4, '0, 0, 0, 0, "R4 all modules disabled");
    wait_neg(5);
    ien = '1;
    push(1, 10'h001, 0, 0, 0, "R4 pending after enable");
    push(2, 10'h001, 0, 1, 1, "R8 summary after enable");
    wait_neg(3);
    req_n = '1;
    wait_neg(6);

    // R7 carrier pass-through gating
    cien = 1'b0; req_n[6] = 1'b0;
    push(4, 10'h040, 0, 1, 0, "R7 host blocked R8 summary set");
    wait_neg(5);
    cien = 1'b1;
    push(1, 10'h040, 0, 1, 1, "R7 host follows enable");
    wait_neg(3);
    req_n = '1;
    push(4, '0, 0, 0, 0, "R9 host low after release");
    wait_neg(6);

    // R5 time-out enable
    tien = 1'b0; tev = 1'b1;
    push(1, '0, 0, 0, 0, "R5 event ignored when disabled");
    wait_neg(1);
    tev = 1'b0;
    push(2, '0, 0, 0, 0, "R5 still clear");
    wait_neg(3);
    tien = 1'b1; tev = 1'b1;
    push(1, '0, 1, 0, 0, "R5 set when enabled");
    push(2, '0, 1, 1, 1, "R8 R7 time-out reaches host");
    wait_neg(1);
    tev = 1'b0;
    wait_neg(3);

    // R10 enable removal keeps bit
    tien = 1'b0;
    push(3, '0, 1, 1, 1, "R10 sticky after enable drop");
    wait_neg(4);

    // R6 set wins over clear, then clear alone
    tien = 1'b1; tev = 1'b1; tclr = 1'b1;
    push(1, '0, 1, 1, 1, "R6 set wins over clear");
    wait_neg(1);
    tev = 1'b0;
    push(1, '0, 0, 1, 1, "R6 clear by write one");
    push(2, '0, 0, 0, 0, "R9 host falls after time-out clear");
    wait_neg(1);
    tclr = 1'b0;
    wait_neg(3);

    // R1 reset while active
    req_n[0] = 1'b0; tev = 1'b1;
    wait_neg(1);
    tev = 1'b0;
    wait_neg(5);
    rst = 1'b1;
    push(1, '0, 0, 0, 0, "R1 reset clears active state");
    wait_neg(1);
    rst = 1'b0;
    push(3, 10'h001, 0, 0, 0, "R3 request returns after reset");
    wait_neg(6);
    req_n = '1;
    wait_neg(6);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule